// File: doc/BRIEF.md
# Indirect Register and Memory Access Bridge

The bridge gives a host a small I/O window of four 32-bit registers. Through this window the host reaches an internal register file and an internal memory, and it does not map either of them directly. Each target has its own pair of registers: an address/control register and a data register. The address/control register holds a target address and a direction flag.

When the host writes an address with the direction flag set to read, the bridge fetches the addressed word into the data register by itself. The host's next data read then returns that word. When the direction flag is clear, a host write to the data register sends one write cycle to the target at the latched address. The two windows are independent copies of one access engine, and each has its own bus and its own busy flag.

Each engine is a three-state machine:

| State | Meaning | Transitions |
|-------|---------|-------------|
| `WIN_IDLE` | No access is in progress. | `START_FETCH`: a host write to the address register with the direction flag set goes to `WIN_FETCH`. `START_STORE`: a host write to the data register while the latched direction is write goes to `WIN_STORE`. |
| `WIN_FETCH` | A read request is held on the bus. | `FETCH_DONE`: on acknowledge, the returned word is loaded into the data register and the state goes back to `WIN_IDLE`. |
| `WIN_STORE` | A write request is held on the bus. | `STORE_DONE`: on acknowledge, the state goes back to `WIN_IDLE`. |

Top module: `ioacc_bridge`

## Requirements
- R1: After reset, all four window registers read zero, both busy flags are low and neither bus requests.
- R2: The host selects a window register with `host_addr[3:2]`: 0 is the register-window address, 1 is the register-window data, 2 is the memory-window address and 3 is the memory-window data. Register-window address layout: bits 13:0 hold the address, bit 14 is the direction (1 = read) and every other bit reads zero. Memory-window address layout: bits 23:0 hold the address, bit 31 is the direction and every other bit reads zero. Data registers read back zero-extended (16 bits for the register window, 24 bits for the memory window).
- R3: A host write to an address register with the direction bit set starts a fetch. In the cycle after the write, the bus request is high, the write-enable is low and the bus address equals the written address.
- R4: When a fetch is acknowledged, the data register takes the bus read data and busy falls in the following cycle.
- R5: While a fetch is in progress, a host read of that window's data register returns its previous value.
- R6: In write direction, a host write to the data register produces exactly one bus write carrying the latched address and the written data. Request, address, write-enable and write data stay stable until acknowledge.
- R7: In read direction, a host write to the data register stores the value and starts no bus cycle.
- R8: While a window is busy, host writes to its address or data register are ignored.
- R9: The two windows operate independently. Either window may be busy while the other accepts host writes and runs its own accesses.
- R10: A host write to an address register with the direction bit clear starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 4 | Host byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected offset |
| rg_busy | output | 1 | Register window access in progress |
| mm_busy | output | 1 | Memory window access in progress |
| rg_req | output | 1 | Register bus request |
| rg_we | output | 1 | Register bus write-enable |
| rg_addr | output | 14 | Register bus address |
| rg_wdata | output | 16 | Register bus write data |
| rg_rdata | input | 16 | Register bus read data |
| rg_ack | input | 1 | Register bus acknowledge |
| mm_req | output | 1 | Memory bus request |
| mm_we | output | 1 | Memory bus write-enable |
| mm_addr | output | 24 | Memory bus address |
| mm_wdata | output | 24 | Memory bus write data |
| mm_rdata | input | 24 | Memory bus read data |
| mm_ack | input | 1 | Memory bus acknowledge |

## Verification
An engine stuck outside `WIN_IDLE` shows at once as a busy flag that never falls. A wrong transition shows on the next bus cycle as a request with the wrong write-enable, or as a request that is missing or extra. A corrupted address or direction latch shows in the address readback on the next host read, and on the bus one cycle after the triggering write. A fetch that loads the wrong word, or loads it at the wrong time, shows in the data readback during the busy window or right after busy falls. For these reasons, the sweeps compare readback and bus values on every cycle in which the requirements fix them, across acknowledge latencies of zero to three cycles.

// File: rtl/ioacc_pkg.sv
package ioacc_pkg;

    localparam int HOST_W   = 32;
    localparam int HOST_OFW = 4;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_FETCH = 2'd1,
        WIN_STORE = 2'd2
    } win_state_e;

endpackage

// File: rtl/ioacc_hostmux.sv
module ioacc_hostmux
    import ioacc_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic                  host_wr,
    input  logic [HOST_OFW-1:0]   host_addr,
    input  logic [HOST_W-1:0]     rb_vec [NREG],
    output logic [NREG-1:0]       wr_sel,
    output logic [HOST_W-1:0]     host_rdata
);

    localparam int IDX_W = $clog2(NREG);

    logic [IDX_W-1:0] idx;

    assign idx = host_addr[IDX_W+1:2];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_sel
            assign wr_sel[g] = host_wr && (idx == IDX_W'(g));
        end
    endgenerate

    assign host_rdata = rb_vec[idx];

endmodule

// File: rtl/ioacc_window.sv
module ioacc_window
    import ioacc_pkg::*;
#(
    parameter int AW      = 14,
    parameter int DW      = 16,
    parameter int DIR_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_data,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] addr_rb,
    output logic [HOST_W-1:0] data_rb,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack
);

    win_state_e       state_q, state_d;
    logic [AW-1:0]    addr_q;
    logic             rd_dir_q;
    logic [DW-1:0]    data_q;
    logic             idle;

    assign idle = (state_q == WIN_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (wr_addr && host_wdata[DIR_BIT])
                    state_d = WIN_FETCH;      // START_FETCH
                else if (wr_data && !rd_dir_q)
                    state_d = WIN_STORE;      // START_STORE
            end
            WIN_FETCH: if (bus_ack) state_d = WIN_IDLE;   // FETCH_DONE
            WIN_STORE: if (bus_ack) state_d = WIN_IDLE;   // STORE_DONE
            default:   state_d = WIN_IDLE;
        endcase
    end

    // State and window registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WIN_IDLE;
            addr_q   <= '0;
            rd_dir_q <= 1'b0;
            data_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idle && wr_addr) begin
                addr_q   <= host_wdata[AW-1:0];
                rd_dir_q <= host_wdata[DIR_BIT];
            end
            if (idle && wr_data)
                data_q <= host_wdata[DW-1:0];
            if (state_q == WIN_FETCH && bus_ack)
                data_q <= bus_rdata;
        end
    end

    // Outputs
    always_comb begin
        bus_req   = !idle;
        bus_we    = (state_q == WIN_STORE);
        busy      = !idle;
        bus_addr  = addr_q;
        bus_wdata = data_q;
        addr_rb   = '0;
        addr_rb[AW-1:0]  = addr_q;
        addr_rb[DIR_BIT] = rd_dir_q;
        data_rb   = HOST_W'(data_q);
    end

    p_fetch_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && host_wdata[DIR_BIT] && !busy) |=> (bus_req && !bus_we))
        else $error("fetch did not start");

    p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bus_ack))
        else $error("busy fell without acknowledge");

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)))
        else $error("bus request not held");

    p_no_store_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && rd_dir_q && !busy) |=> !bus_req)
        else $error("write issued in read direction");

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(rd_dir_q)))
        else $error("address changed while busy");

    p_no_cycle_wrdir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && !host_wdata[DIR_BIT] && !busy) |=> !bus_req)
        else $error("bus cycle on write-direction address");

endmodule

// File: rtl/ioacc_bridge.sv
module ioacc_bridge
    import ioacc_pkg::*;
#(
    parameter int REG_AW  = 14,
    parameter int REG_DW  = 16,
    parameter int REG_DIR = 14,
    parameter int MEM_AW  = 24,
    parameter int MEM_DW  = 24,
    parameter int MEM_DIR = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [HOST_OFW-1:0] host_addr,
    input  logic [HOST_W-1:0]   host_wdata,
    output logic [HOST_W-1:0]   host_rdata,
    output logic                rg_busy,
    output logic                mm_busy,
    output logic                rg_req,
    output logic                rg_we,
    output logic [REG_AW-1:0]   rg_addr,
    output logic [REG_DW-1:0]   rg_wdata,
    input  logic [REG_DW-1:0]   rg_rdata,
    input  logic                rg_ack,
    output logic                mm_req,
    output logic                mm_we,
    output logic [MEM_AW-1:0]   mm_addr,
    output logic [MEM_DW-1:0]   mm_wdata,
    input  logic [MEM_DW-1:0]   mm_rdata,
    input  logic                mm_ack
);

    localparam int NREG = 4;

    logic [NREG-1:0]   wr_sel;
    logic [HOST_W-1:0] rb_vec [NREG];

    ioacc_hostmux #(.NREG(NREG)) u_mux (
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .rb_vec     (rb_vec),
        .wr_sel     (wr_sel),
        .host_rdata (host_rdata)
    );

    ioacc_window #(.AW(REG_AW), .DW(REG_DW), .DIR_BIT(REG_DIR)) u_rgwin (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_sel[0]),
        .wr_data    (wr_sel[1]),
        .host_wdata (host_wdata),
        .addr_rb    (rb_vec[0]),
        .data_rb    (rb_vec[1]),
        .busy       (rg_busy),
        .bus_req    (rg_req),
        .bus_we     (rg_we),
        .bus_addr   (rg_addr),
        .bus_wdata  (rg_wdata),
        .bus_rdata  (rg_rdata),
        .bus_ack    (rg_ack)
    );

    ioacc_window #(.AW(MEM_AW), .DW(MEM_DW), .DIR_BIT(MEM_DIR)) u_mmwin (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_sel[2]),
        .wr_data    (wr_sel[3]),
        .host_wdata (host_wdata),
        .addr_rb    (rb_vec[2]),
        .data_rb    (rb_vec[3]),
        .busy       (mm_busy),
        .bus_req    (mm_req),
        .bus_we     (mm_we),
        .bus_addr   (mm_addr),
        .bus_wdata  (mm_wdata),
        .bus_rdata  (mm_rdata),
        .bus_ack    (mm_ack)
    );

    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!rg_req && !mm_req && !rg_busy && !mm_busy))
        else $error("bus active after reset");

    p_own_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr[3] && !rg_busy) |=> !rg_req)
        else $error("memory window write disturbed register bus");

endmodule

// File: tb/ioacc_bridge_tb.sv
module ioacc_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rg_busy, mm_busy;
    logic        rg_req, rg_we;
    logic [13:0] rg_addr;
    logic [15:0] rg_wdata;
    logic [15:0] rg_rdata = '0;
    logic        rg_ack = 1'b0;
    logic        mm_req, mm_we;
    logic [23:0] mm_addr;
    logic [23:0] mm_wdata;
    logic [23:0] mm_rdata = '0;
    logic        mm_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int rlat = 0, mlat = 0;
    int rcnt = 0, mcnt = 0;
    int rg_starts = 0, mm_starts = 0;
    int rg_writes = 0, mm_writes = 0;
    logic [13:0] rg_last_wa; logic [15:0] rg_last_wd;
    logic [23:0] mm_last_wa; logic [23:0] mm_last_wd;
    logic rg_req_prev = 0, mm_req_prev = 0;

    always #5 clk = ~clk;

    ioacc_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rg_busy(rg_busy), .mm_busy(mm_busy),
        .rg_req(rg_req), .rg_we(rg_we), .rg_addr(rg_addr),
        .rg_wdata(rg_wdata), .rg_rdata(rg_rdata), .rg_ack(rg_ack),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_ack(mm_ack)
    );

    function automatic logic [15:0] rg_val(logic [13:0] a);
        return 16'((32'(a) * 32'h3b1) + 32'h77);
    endfunction

    function automatic logic [23:0] mm_val(logic [23:0] a);
        return 24'((32'(a) * 32'h1f3)) ^ 24'h5a5a5a;
    endfunction

    // Register bus model
    initial forever begin
        @(negedge clk);
        if (rg_req && !rg_req_prev) rg_starts++;
        rg_req_prev = rg_req;
        if (rg_req && !rg_ack) begin
            if (rcnt == rlat) begin
                rg_ack = 1'b1;
                rg_rdata = rg_val(rg_addr);
                if (rg_we) begin
                    rg_writes++; rg_last_wa = rg_addr; rg_last_wd = rg_wdata;
                end
            end else rcnt++;
        end else begin
            rg_ack = 1'b0; rcnt = 0;
        end
    end

    // Memory bus model
    initial forever begin
        @(negedge clk);
        if (mm_req && !mm_req_prev) mm_starts++;
        mm_req_prev = mm_req;
        if (mm_req && !mm_ack) begin
            if (mcnt == mlat) begin
                mm_ack = 1'b1;
                mm_rdata = mm_val(mm_addr);
                if (mm_we) begin
                    mm_writes++; mm_last_wa = mm_addr; mm_last_wd = mm_wdata;
                end
            end else mcnt++;
        end else begin
            mm_ack = 1'b0; mcnt = 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [3:0] off, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [3:0] off, output logic [31:0] d);
        host_addr = off;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (rg_busy || mm_busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] rprev;
        logic [23:0] mprev;
        int n0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            hread(4'(k * 4), rd);
            chk("R1 window reg", rd, 32'h0);
        end
        chk("R1 busy/req", {28'h0, rg_busy, mm_busy, rg_req, mm_req}, 32'h0);

        // R2 + R10: layout masks, write direction starts nothing
        n0 = rg_starts;
        hwrite(4'h0, 32'hFFFF_BFFF);
        hread(4'h0, rd);
        chk("R2 reg addr layout", rd, 32'h0000_3FFF);
        chk("R10 reg no req", {31'h0, rg_req}, 32'h0);
        hwrite(4'h8, 32'h7FFF_FFFF);
        hread(4'h8, rd);
        chk("R2 mem addr layout", rd, 32'h00FF_FFFF);
        chk("R10 mem no req", {31'h0, mm_req}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 start count", 32'(rg_starts - n0), 32'h0);

        // Register window fetch sweep
        rprev = 16'h0;
        hwrite(4'h4, 32'h0);
        for (int lat = 0; lat < 4; lat++) begin
            rlat = lat;
            for (int i = 0; i < 8; i++) begin
                logic [13:0] a;
                a = 14'(i * 32'h0813 + lat * 5);
                hwrite(4'h0, 32'h4000 | 32'(a));
                chk("R3 req/we", {30'h0, rg_req, rg_we}, 32'h2);
                chk("R3 addr", 32'(rg_addr), 32'(a));
                hread(4'h4, rd);
                chk("R5 prev data", rd, 32'(rprev));
                hread(4'h0, rd);
                chk("R2 read dir", rd, 32'h4000 | 32'(a));
                wait_idle();
                hread(4'h4, rd);
                chk("R4 fetched", rd, 32'(rg_val(a)));
                rprev = rg_val(a);
            end
        end

        // Register window write sweep
        for (int lat = 0; lat < 4; lat++) begin
            rlat = lat;
            for (int i = 0; i < 6; i++) begin
                logic [13:0] a; logic [15:0] d;
                a = 14'(i * 32'h0a31 + lat);
                d = 16'(i * 32'h1111 + lat * 32'h0f0f);
                hwrite(4'h0, 32'(a));
                n0 = rg_writes;
                hwrite(4'h4, 32'hABCD_0000 | 32'(d));
                chk("R6 req/we", {30'h0, rg_req, rg_we}, 32'h3);
                chk("R6 bus addr", 32'(rg_addr), 32'(a));
                chk("R6 bus data", 32'(rg_wdata), 32'(d));
                wait_idle();
                repeat (2) @(negedge clk);
                chk("R6 one write", 32'(rg_writes - n0), 32'h1);
                chk("R6 logged", {2'b0, rg_last_wa, rg_last_wd}, {2'b0, a, d});
            end
        end

        // R7: data write in read direction
        rlat = 1;
        hwrite(4'h0, 32'h4000 | 32'h0055);
        wait_idle();
        n0 = rg_starts;
        hwrite(4'h4, 32'h0000_1234);
        repeat (5) @(negedge clk);
        chk("R7 no cycle", 32'(rg_starts - n0), 32'h0);
        hread(4'h4, rd);
        chk("R7 stored", rd, 32'h1234);

        // R8: writes ignored while busy
        rlat = 3;
        hwrite(4'h0, 32'h4000 | 32'h0321);
        hwrite(4'h0, 32'h0000_0123);
        hwrite(4'h4, 32'h0000_DEAD);
        wait_idle();
        hread(4'h0, rd);
        chk("R8 addr kept", rd, 32'h4321);
        hread(4'h4, rd);
        chk("R8 data fetched", rd, 32'(rg_val(14'h0321)));

        // Memory window sweeps
        mprev = 24'h0;
        hwrite(4'hC, 32'h0);
        for (int lat = 0; lat < 4; lat++) begin
            mlat = lat;
            for (int i = 0; i < 6; i++) begin
                logic [23:0] a; logic [23:0] d;
                a = 24'(i * 32'h13579 + lat * 32'h8001);
                hwrite(4'h8, 32'h8000_0000 | 32'(a));
                chk("R3 mem req/we", {30'h0, mm_req, mm_we}, 32'h2);
                chk("R3 mem addr", 32'(mm_addr), 32'(a));
                hread(4'hC, rd);
                chk("R5 mem prev", rd, 32'(mprev));
                wait_idle();
                hread(4'hC, rd);
                chk("R4 mem fetched", rd, 32'(mm_val(a)));
                d = 24'(i * 32'h0abcde + lat);
                hwrite(4'h8, 32'(a));
                n0 = mm_writes;
                hwrite(4'hC, 32'(d));
                wait_idle();
                repeat (2) @(negedge clk);
                chk("R6 mem write", {8'(mm_writes - n0), mm_last_wd}, {8'h1, d});
                chk("R6 mem addr", 32'(mm_last_wa), 32'(a));
                hread(4'hC, rd);
                mprev = rd[23:0];
            end
        end

        // R9: independence
        rlat = 3; mlat = 2;
        hwrite(4'h0, 32'h4000 | 32'h0777);
        chk("R9 reg busy", {30'h0, rg_busy, mm_busy}, 32'h2);
        hwrite(4'h8, 32'h8000_0000 | 32'h00ABCD);
        chk("R9 mem busy", {31'h0, mm_busy}, 32'h1);
        wait_idle();
        hread(4'h4, rd);
        chk("R9 reg data", rd, 32'(rg_val(14'h0777)));
        hread(4'hC, rd);
        chk("R9 mem data", rd, 32'(mm_val(24'h00ABCD)));
        hread(4'h8, rd);
        chk("R9 mem addr", rd, 32'h8000_0000 | 32'h00ABCD);

        done = 1;
        finish_run();
    end

endmodule